// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block watches the stream of completed requests at the write side of a data cache and keeps a small table of line reservations. A completed load-linked takes a reservation for its line and tags it with the requester's identifier. A completed store-conditional succeeds only when that same requester still holds the reservation, and it removes the line's reservation whatever the outcome. Ordinary writes and read-modify-write halves drop a reservation that the writing requester holds. Plain loads and instruction fetches leave the table alone.

Each completion is presented for one cycle on a strobe, together with an operation code, the line address and the requester identifier. Exactly one cycle later the monitor returns a success flag and a result word for the processor. The result word is 1 for a store-conditional that succeeded and 0 in every other case. An invalidate input lets the coherence logic remove the reservation on a named line. The table has a fixed number of slots. When a new reservation arrives with no free slot, the slot that was allocated longest ago is replaced.

Top module: `llsc_monitor`

## Requirements
- R1: Every cycle with `cmplValid` high is followed, in the next cycle only, by `rspValid` high; in a cycle where `rspValid` is low, `rspSuccess` and `rspWord` are both 0.
- R2: A completion with `cmplKind` = 5 (load-linked) reserves `cmplLine` for `cmplOwner` and responds with success 1 and word 0.
- R3: A completion with `cmplKind` = 6 (store-conditional) responds with success 1 and word 1 when the line is reserved by the same requester, and with success 0 and word 0 otherwise.
- R4: After any store-conditional the line holds no reservation, whether it succeeded or failed and whichever requester held the line.
- R5: A completion with `cmplKind` = 2, 3 or 4 (store, read half of a read-modify-write, write half of a read-modify-write) removes the line's reservation only when `cmplOwner` holds it, and responds with success 1 and word 0.
- R6: A completion with `cmplKind` = 0, 1 or 7 (load, instruction fetch, spare code) leaves every reservation unchanged and responds with success 1 and word 0.
- R7: A load-linked to a line that is already reserved moves the reservation to the new requester and counts as the newest allocation; a line never holds two reservations.
- R8: The table holds `NUM_SLOTS` reservations; a load-linked to a new line with the table full replaces the reservation allocated longest ago.
- R9: `invValid` removes the reservation on `invLine`. A completion in the same cycle is judged on the table as it stood before the invalidate, and a load-linked to the invalidated line in that cycle leaves no reservation.
- R10: Reset empties the table and holds `rspValid`, `rspSuccess` and `rspWord` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmplValid | input | 1 | One completed request this cycle |
| cmplKind | input | 3 | Operation code of the completion |
| cmplLine | input | ADDR_W | Line address of the completion |
| cmplOwner | input | ID_W | Requester identifier of the completion |
| invValid | input | 1 | Invalidate strobe |
| invLine | input | ADDR_W | Line address to invalidate |
| rspValid | output | 1 | Response present, one cycle after the completion |
| rspSuccess | output | 1 | Operation succeeded |
| rspWord | output | RESULT_W | Result value for the processor |

## Verification
The assertions assume nothing about the inputs beyond reset: any operation code, any line, and an invalidate that may coincide with a completion on the same line are all legal, so they rely only on the monitor keeping one reservation per line. To exercise this, the stimulus draws lines from a pool slightly larger than the table, so eviction, takeover by a second requester and collisions between invalidates and completions occur often. All eight operation codes are used, and directed sequences reach each ordering that a random run might miss.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_FETCH   = 3'd1,
    OP_STORE   = 3'd2,
    OP_RMW_RD  = 3'd3,
    OP_RMW_WR  = 3'd4,
    OP_LOCK_RD = 3'd5,
    OP_LOCK_WR = 3'd6,
    OP_SPARE   = 3'd7
  } opKind_e;

  // Strobes from control to the slot datapath
  typedef struct packed {
    logic alloc;     // take or refresh a reservation for the completion line
    logic clrLine;   // drop the line's reservation, any owner
    logic clrOwned;  // drop the line's reservation if the completion owner holds it
  } slotCmd_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int RESULT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmplValid,
  input  logic [2:0]          cmplKind,
  input  logic                ownedHit,
  output slotCmd_t            cmd,
  output logic                rspValid,
  output logic                rspSuccess,
  output logic [RESULT_W-1:0] rspWord
);

  opKind_e kind;
  logic    isLockRd, isLockWr, isPlainWrite;
  logic    scWin;

  always_comb begin
    kind         = opKind_e'(cmplKind);
    isLockRd     = cmplValid && (kind == OP_LOCK_RD);
    isLockWr     = cmplValid && (kind == OP_LOCK_WR);
    isPlainWrite = cmplValid && ((kind == OP_STORE) || (kind == OP_RMW_RD) ||
                                 (kind == OP_RMW_WR));
    cmd.alloc    = isLockRd;
    cmd.clrLine  = isLockWr;
    cmd.clrOwned = isPlainWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspSuccess <= 1'b0;
      scWin      <= 1'b0;
    end else begin
      rspValid   <= cmplValid;
      rspSuccess <= cmplValid && !(isLockWr && !ownedHit);
      scWin      <= isLockWr && ownedHit;
    end
  end

  assign rspWord = {{(RESULT_W-1){1'b0}}, scWin};

  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |=> rspValid);
  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmplValid |=> (!rspValid && !rspSuccess && rspWord == '0));
  // R3
  sc_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && cmplKind == 3'd6 && ownedHit) |=> (rspSuccess && rspWord == RESULT_W'(1)));
  // R3
  sc_lose_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && cmplKind == 3'd6 && !ownedHit) |=> (!rspSuccess && rspWord == '0));

endmodule

// File: rtl/llsc_slots.sv
module llsc_slots
  import llsc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotCmd_t          cmd,
  input  logic [ADDR_W-1:0] cmplLine,
  input  logic [ID_W-1:0]   cmplOwner,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invLine,
  output logic              ownedHit
);

  localparam int N = NUM_SLOTS;

  logic [N-1:0]      slotValid;
  logic [ADDR_W-1:0] slotLine  [N];
  logic [ID_W-1:0]   slotOwner [N];
  // olderThan[i][j] set: slot i was allocated before slot j
  logic [N-1:0]      olderThan [N];

  logic [N-1:0] lineHit, ownHit, invHit, clrHit;
  logic [N-1:0] freePick, oldest, target;
  logic         gotFree, invSameLine;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lineHit[g] = slotValid[g] && (slotLine[g] == cmplLine);
    assign ownHit[g]  = slotOwner[g] == cmplOwner;
    assign invHit[g]  = invValid && slotValid[g] && (slotLine[g] == invLine);
    assign clrHit[g]  = (cmd.clrLine && lineHit[g]) ||
                        (cmd.clrOwned && lineHit[g] && ownHit[g]) ||
                        invHit[g];
  end

  assign ownedHit    = |(lineHit & ownHit);
  assign invSameLine = invValid && (invLine == cmplLine);

  // Lowest-numbered free slot
  always_comb begin
    freePick = '0;
    gotFree  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!slotValid[i] && !gotFree) begin
        freePick[i] = 1'b1;
        gotFree     = 1'b1;
      end
    end
  end

  // Slot allocated before every other valid slot
  always_comb begin
    for (int i = 0; i < N; i++) begin
      oldest[i] = slotValid[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && slotValid[j] && !olderThan[i][j]) oldest[i] = 1'b0;
      end
    end
  end

  always_comb begin
    if (|lineHit)     target = lineHit;
    else if (gotFree) target = freePick;
    else              target = oldest;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int i = 0; i < N; i++) begin
        slotLine[i]  <= '0;
        slotOwner[i] <= '0;
        olderThan[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cmd.alloc && target[i]) begin
          slotValid[i] <= !invSameLine;
          slotLine[i]  <= cmplLine;
          slotOwner[i] <= cmplOwner;
        end else if (clrHit[i]) begin
          slotValid[i] <= 1'b0;
        end
        for (int j = 0; j < N; j++) begin
          if (j != i) begin
            if (cmd.alloc && target[i])      olderThan[i][j] <= 1'b0;
            else if (cmd.alloc && target[j]) olderThan[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  // ---------------- checks on the table ----------------
  logic              prbAlloc, prbSc, prbInv;
  logic [ADDR_W-1:0] prbLine, prbInvLine;
  logic [ID_W-1:0]   prbOwner;
  logic              prbOwned, prbLinePresent, prbInvPresent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prbAlloc   <= 1'b0;
      prbSc      <= 1'b0;
      prbInv     <= 1'b0;
      prbLine    <= '0;
      prbInvLine <= '0;
      prbOwner   <= '0;
    end else begin
      prbAlloc   <= cmd.alloc && !invSameLine;
      prbSc      <= cmd.clrLine;
      prbInv     <= invValid;
      prbLine    <= cmplLine;
      prbInvLine <= invLine;
      prbOwner   <= cmplOwner;
    end
  end

  always_comb begin
    prbOwned       = 1'b0;
    prbLinePresent = 1'b0;
    prbInvPresent  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (slotValid[i] && slotLine[i] == prbLine) begin
        prbLinePresent = 1'b1;
        if (slotOwner[i] == prbOwner) prbOwned = 1'b1;
      end
      if (slotValid[i] && slotLine[i] == prbInvLine) prbInvPresent = 1'b1;
    end
  end

  // R2
  ll_reserves_chk: assert property (@(posedge clk) disable iff (!rstN)
    prbAlloc |-> prbOwned);
  // R4
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    prbSc |-> !prbLinePresent);
  // R9
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    prbInv |-> !prbInvPresent);
  // R7
  one_per_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lineHit));
  // R8
  single_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&slotValid) |-> ($countones(oldest) == 1));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 4,
  parameter int RESULT_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmplValid,
  input  logic [2:0]          cmplKind,
  input  logic [ADDR_W-1:0]   cmplLine,
  input  logic [ID_W-1:0]     cmplOwner,
  input  logic                invValid,
  input  logic [ADDR_W-1:0]   invLine,
  output logic                rspValid,
  output logic                rspSuccess,
  output logic [RESULT_W-1:0] rspWord
);

  slotCmd_t cmd;
  logic     ownedHit;

  llsc_ctrl #(.RESULT_W(RESULT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmplValid  (cmplValid),
    .cmplKind   (cmplKind),
    .ownedHit   (ownedHit),
    .cmd        (cmd),
    .rspValid   (rspValid),
    .rspSuccess (rspSuccess),
    .rspWord    (rspWord)
  );

  llsc_slots #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W)
  ) u_slots (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .cmplLine  (cmplLine),
    .cmplOwner (cmplOwner),
    .invValid  (invValid),
    .invLine   (invLine),
    .ownedHit  (ownedHit)
  );

endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;

  localparam int NS = 4;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cmplValid, invValid;
  logic [2:0]    cmplKind;
  logic [AW-1:0] cmplLine, invLine;
  logic [IW-1:0] cmplOwner;
  logic          rspValid, rspSuccess;
  logic [RW-1:0] rspWord;

  always #10 clk = ~clk;

  llsc_monitor #(.NUM_SLOTS(NS), .ADDR_W(AW), .ID_W(IW), .RESULT_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .cmplKind(cmplKind),
    .cmplLine(cmplLine), .cmplOwner(cmplOwner), .invValid(invValid),
    .invLine(invLine), .rspValid(rspValid), .rspSuccess(rspSuccess),
    .rspWord(rspWord)
  );

  typedef struct {int line; int owner;} resv_t;
  resv_t book[$];   // oldest allocation at the front

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;
  bit  expValid, expSucc;
  int  expWord;

  function automatic int findLine(int line);
    foreach (book[k]) if (book[k].line == line) return k;
    return -1;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (rspValid !== expValid || rspSuccess !== expSucc || rspWord !== RW'(expWord)) begin
      fails++;
      $display("FAIL %s: got valid=%0b success=%0b word=%0d, expected valid=%0b success=%0b word=%0d",
               tag, rspValid, rspSuccess, rspWord, expValid, expSucc, expWord);
    end
  endtask

  // One cycle: drive at a falling edge, update the model, compare at the next falling edge
  task automatic step(bit v, int k, int line, int owner, bit iv, int il, string tag);
    int  idx;
    bit  owned;
    cmplValid = v;
    cmplKind  = k[2:0];
    cmplLine  = line[AW-1:0];
    cmplOwner = owner[IW-1:0];
    invValid  = iv;
    invLine   = il[AW-1:0];
    idx   = findLine(line);
    owned = (idx >= 0) && (book[idx].owner == owner);
    expValid = v; expSucc = 0; expWord = 0;
    if (v) begin
      expSucc = 1;
      case (k)
        5: begin
          if (idx >= 0) book.delete(idx);
          if (book.size() == NS) void'(book.pop_front());
          book.push_back('{line, owner});
        end
        6: begin
          expSucc = owned;
          expWord = owned ? 1 : 0;
          if (idx >= 0) book.delete(idx);
        end
        2, 3, 4: if (owned) book.delete(idx);
        default: ;
      endcase
    end
    if (iv) begin
      idx = findLine(il);
      if (idx >= 0) book.delete(idx);
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  function automatic string tagOf(bit v, int k);
    if (!v) return "R1";
    case (k)
      5: return "R2";
      6: return "R3";
      2, 3, 4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    rstN = 0; cmplValid = 0; cmplKind = 0; cmplLine = 0; cmplOwner = 0;
    invValid = 0; invLine = 0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    expValid = 0; expSucc = 0; expWord = 0;
    compare("R10");
    rstN = 1;
    // R10: empty table, so a store-conditional fails
    step(1, 6, 1, 0, 0, 0, "R10");
    idle("R1");

    // R2, R3: reserve then succeed
    step(1, 5, 10, 1, 0, 0, "R2");
    step(1, 6, 10, 1, 0, 0, "R3");
    // R4: second attempt fails after a success
    step(1, 6, 10, 1, 0, 0, "R4");

    // R4: failed attempt by another owner still clears
    step(1, 5, 11, 1, 0, 0, "R2");
    step(1, 6, 11, 2, 0, 0, "R3");
    step(1, 6, 11, 1, 0, 0, "R4");

    // R5: foreign store keeps, own write-half drops
    step(1, 5, 12, 1, 0, 0, "R2");
    step(1, 2, 12, 2, 0, 0, "R5");
    step(1, 3, 12, 3, 0, 0, "R5");
    step(1, 6, 12, 1, 0, 0, "R5");
    step(1, 5, 12, 1, 0, 0, "R2");
    step(1, 4, 12, 1, 0, 0, "R5");
    step(1, 6, 12, 1, 0, 0, "R5");

    // R6: reads leave a reservation alone
    step(1, 5, 13, 3, 0, 0, "R2");
    step(1, 0, 13, 3, 0, 0, "R6");
    step(1, 1, 13, 3, 0, 0, "R6");
    step(1, 7, 13, 3, 0, 0, "R6");
    step(1, 6, 13, 3, 0, 0, "R6");

    // R7: takeover by a second requester
    step(1, 5, 14, 1, 0, 0, "R7");
    step(1, 5, 14, 2, 0, 0, "R7");
    step(1, 6, 14, 1, 0, 0, "R7");
    step(1, 5, 14, 2, 0, 0, "R7");
    step(1, 6, 14, 2, 0, 0, "R7");

    // R8: fill beyond capacity, oldest line is lost
    for (int i = 0; i <= NS; i++) step(1, 5, 20 + i, 1, 0, 0, "R8");
    step(1, 6, 20, 1, 0, 0, "R8");
    for (int i = 1; i <= NS; i++) step(1, 6, 20 + i, 1, 0, 0, "R8");
    // R8 with a refreshed line: refresh makes line 30 youngest
    for (int i = 0; i < NS; i++) step(1, 5, 30 + i, 2, 0, 0, "R8");
    step(1, 5, 30, 2, 0, 0, "R7");
    step(1, 5, 40, 2, 0, 0, "R8");
    step(1, 6, 31, 2, 0, 0, "R8");
    step(1, 6, 30, 2, 0, 0, "R8");

    // R9: invalidate alone, with same-cycle reserve, with same-cycle attempt
    step(1, 5, 50, 1, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 50, "R9");
    step(1, 6, 50, 1, 0, 0, "R9");
    step(1, 5, 51, 1, 1, 51, "R9");
    step(1, 6, 51, 1, 0, 0, "R9");
    step(1, 5, 52, 1, 0, 0, "R2");
    step(1, 6, 52, 1, 1, 52, "R9");
    step(1, 5, 53, 1, 0, 0, "R2");
    step(1, 2, 53, 1, 1, 54, "R9");
    step(1, 6, 53, 1, 0, 0, "R9");

    // Mixed traffic on a small line pool
    for (int n = 0; n < 4000; n++) begin
      bit v, iv;
      int k;
      v  = ($urandom_range(0, 3) != 0);
      k  = $urandom_range(0, 7);
      iv = ($urandom_range(0, 7) == 0);
      step(v, k, $urandom_range(0, 5), $urandom_range(0, 2), iv,
           $urandom_range(0, 5), tagOf(v, k));
    end
    idle("R1");
    summary();
  end

endmodule